// File: doc/BRIEF.md
# Vector Status Register Controller

This block owns the 64-bit status word of a vector unit. The word holds a mask-mode flag, eight in-use bits and eight changed bits (one of each per even/odd register pair), a vector count and an interruption index. A sequencer sends one operation per cycle with `op_valid`. Every operation finishes in one cycle. Its results, a `done` pulse, and any error or clear pulses all appear together on the cycle after the operation is accepted.

There are five operations. The count and index loads take a signed 32-bit value, clamp it into range, and report through a 2-bit condition code how the value compared with the limits. Set-mode copies a single bit into the mask-mode flag. Clear-pairs takes an 8-bit mask: it drops the in-use bit of each selected pair and strobes that pair's clear line, which goes to an external register file. Restore loads a complete status word. It first checks the word's fields. It then strobes a clear for every pair that is in use now but is not in use in the incoming word. In problem state it rebuilds the changed bits from the incoming in-use bits.

Top module: `vsr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word, condition code, `done`, `spec_err` and `pair_clr` all become zero.
- R2: Op code 1 loads the count field [47:32] from `operand[31:0]`, read as signed. Values below 0 store 0, values above SECT_SIZE store SECT_SIZE, and other values store unchanged. The condition code is 0 for zero, 1 for negative, 2 for above SECT_SIZE and 3 otherwise.
- R3: Op code 2 loads the index field [31:16] with the same clamping as R2. The condition code is 0 for zero, 1 for negative, 2 when the value is below the count held before the operation, and 3 otherwise.
- R4: Op code 3 copies `operand[0]` into the mask-mode bit 15 and leaves every other bit of the word unchanged.
- R5: Op code 4 zeroes the index field and clears in-use bit 56+j for each set bit j of `operand[7:0]`. Mask bit 7 (0x80) selects pair 0, which is in-use bit 63. `pair_clr` equals `operand[7:0]` for one cycle, and the changed bits [55:48] are untouched.
- R6: Op code 5 rejects the word when reserved bits [14:0] are nonzero, when the count field is above SECT_SIZE, or when the index field is at or above SECT_SIZE. A rejected word pulses `spec_err`, leaves the status word unchanged and strobes no clears.
- R7: An accepted restore with `prob_state` low copies `operand` into the status word unchanged.
- R8: An accepted restore with `prob_state` high writes the changed bits [55:48] with the incoming in-use bits [63:56]. All other bits come from `operand`.
- R9: An accepted restore drives `pair_clr` to the old in-use bits AND NOT the incoming in-use bits for one cycle.
- R10: Each accepted operation, including the unused codes 0, 6 and 7, pulses `done` exactly one cycle later. The unused codes change nothing. Only op codes 1 and 2 change the condition code.
- R11: Cycles without `op_valid` leave the status word and condition code unchanged and keep `done`, `spec_err` and `pair_clr` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (1 count, 2 index, 3 mode, 4 clear, 5 restore) |
| operand | input | 64 | Operation data: signed value, mode bit, pair mask or full word |
| prob_state | input | 1 | Restore runs in problem state |
| vsr | output | 64 | Current status word |
| cc | output | 2 | Condition code of the last load |
| done | output | 1 | One-cycle completion pulse |
| spec_err | output | 1 | One-cycle pulse for a rejected restore |
| pair_clr | output | 8 | One-cycle clear strobes, bit 7 for pair 0 |

## Verification
The bench builds the block with SECT_SIZE set to 16. This keeps every clamp boundary close to small operands: a count of exactly 16 against 17, an index of exactly 15 against 16, and negative values that must floor at zero. With a count of 9, the index load can be driven below, at and above the current count, which reaches all of its condition codes. Restore words are chosen so that each of the three rejection causes appears on its own. Accepted restores are chosen so that in-use bits drop, in both supervisor and problem state.

// File: rtl/vsr_pkg.sv
// Shared definitions for the vector status register controller.
// Assumes a fixed 64-bit word layout; only the section size varies.
package vsr_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LOAD_CNT = 3'd1,
        OP_LOAD_IDX = 3'd2,
        OP_SET_MODE = 3'd3,
        OP_CLEAR    = 3'd4,
        OP_RESTORE  = 3'd5
    } vsr_op_e;

    localparam int WORD_W    = 64;
    localparam int PAIRS     = 8;
    localparam int FLD_W     = 16;
    localparam int INUSE_LSB = 56;
    localparam int CHG_LSB   = 48;
    localparam int CNT_LSB   = 32;
    localparam int IDX_LSB   = 16;
    localparam int MODE_BIT  = 15;
    localparam int RSV_W     = 15;
endpackage

// File: rtl/vsr_limit_unit.sv
// Clamps a signed 32-bit operand into 0..SECT_SIZE and grades it into a
// condition code. IS_INDEX picks the grading rule for code 2: above the
// reference (count variant) or below it (index variant). The reference
// is SECT_SIZE for the count variant and the live count for the index one.
module vsr_limit_unit #(
    parameter int SECT_SIZE = 128,
    parameter bit IS_INDEX  = 1'b0
) (
    input  logic [31:0] value,
    input  logic [15:0] cmp_ref,
    output logic [15:0] clamped,
    output logic [1:0]  code
);
    localparam logic signed [31:0] LIM = 32'(SECT_SIZE);

    logic signed [31:0] sval;
    logic signed [31:0] sref;
    logic               hit2;

    assign sval = $signed(value);
    assign sref = $signed({16'h0000, cmp_ref});

    // Select the rule that yields condition code 2
    generate
        if (IS_INDEX) begin : g_idx_rule
            assign hit2 = sval < sref;
        end else begin : g_cnt_rule
            assign hit2 = sval > sref;
        end
    endgenerate

    // Grade the operand: zero, negative, rule hit, otherwise
    always_comb begin
        if (sval == 32'sd0)      code = 2'd0;
        else if (sval < 32'sd0)  code = 2'd1;
        else if (hit2)           code = 2'd2;
        else                     code = 2'd3;
    end

    // Clamp the operand into 0..SECT_SIZE
    always_comb begin
        if (sval < 32'sd0)      clamped = '0;
        else if (sval > LIM)    clamped = LIM[15:0];
        else                    clamped = sval[15:0];
    end
endmodule

// File: rtl/vsr_restore_check.sv
// Validates an incoming status word and derives what a restore writes.
// Assumes reserved bits sit below the mode bit and in-use bits sit
// exactly PAIRS positions above the changed bits.
module vsr_restore_check
    import vsr_pkg::*;
#(
    parameter int SECT_SIZE = 128
) (
    input  logic [WORD_W-1:0] word,
    input  logic              prob_state,
    input  logic [PAIRS-1:0]  cur_inuse,
    output logic              ok,
    output logic [WORD_W-1:0] fixed,
    output logic [PAIRS-1:0]  clr
);
    localparam logic [FLD_W-1:0] SECT_F = FLD_W'(SECT_SIZE);

    logic [PAIRS-1:0] new_inuse;
    logic [FLD_W-1:0] new_cnt;
    logic [FLD_W-1:0] new_idx;

    assign new_inuse = word[INUSE_LSB +: PAIRS];
    assign new_cnt   = word[CNT_LSB +: FLD_W];
    assign new_idx   = word[IDX_LSB +: FLD_W];

    // Field validation: reserved clear, count within section, index below it
    always_comb begin
        ok = (word[RSV_W-1:0] == '0) && (new_cnt <= SECT_F) && (new_idx < SECT_F);
    end

    // Word to store: in problem state the changed bits mirror in-use bits
    always_comb begin
        fixed = word;
        if (prob_state) fixed[CHG_LSB +: PAIRS] = new_inuse;
    end

    // Pairs that drop out of use must be cleared
    always_comb begin
        clr = cur_inuse & ~new_inuse;
    end
endmodule

// File: rtl/vsr_ctrl.sv
// Vector status register controller. Executes one operation per cycle:
// count load, index load, mask-mode set, pair clear and full restore.
// Results, done, error and clear strobes register on the same edge.
// Assumes the sequencer holds no more than one operation per cycle.
module vsr_ctrl
    import vsr_pkg::*;
#(
    parameter int SECT_SIZE = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [63:0] operand,
    input  logic        prob_state,
    output logic [63:0] vsr,
    output logic [1:0]  cc,
    output logic        done,
    output logic        spec_err,
    output logic [7:0]  pair_clr
);
    localparam logic [FLD_W-1:0] SECT_F = FLD_W'(SECT_SIZE);

    vsr_op_e          op;
    logic [WORD_W-1:0] vsr_q, vsr_d;
    logic [1:0]       cc_q, cc_d;
    logic             done_q, err_q, err_d;
    logic [PAIRS-1:0] clr_q, clr_d;

    logic [FLD_W-1:0] cnt_val, idx_val;
    logic [1:0]       cnt_cc, idx_cc;
    logic             rst_ok;
    logic [WORD_W-1:0] rst_word;
    logic [PAIRS-1:0] rst_clr;

    assign op = vsr_op_e'(op_code);

    vsr_limit_unit #(.SECT_SIZE(SECT_SIZE), .IS_INDEX(1'b0)) u_cnt_lim (
        .value   (operand[31:0]),
        .cmp_ref (SECT_F),
        .clamped (cnt_val),
        .code    (cnt_cc)
    );

    vsr_limit_unit #(.SECT_SIZE(SECT_SIZE), .IS_INDEX(1'b1)) u_idx_lim (
        .value   (operand[31:0]),
        .cmp_ref (vsr_q[CNT_LSB +: FLD_W]),
        .clamped (idx_val),
        .code    (idx_cc)
    );

    vsr_restore_check #(.SECT_SIZE(SECT_SIZE)) u_rst_chk (
        .word       (operand),
        .prob_state (prob_state),
        .cur_inuse  (vsr_q[INUSE_LSB +: PAIRS]),
        .ok         (rst_ok),
        .fixed      (rst_word),
        .clr        (rst_clr)
    );

    // Next-state selection for the accepted operation
    always_comb begin
        vsr_d = vsr_q;
        cc_d  = cc_q;
        err_d = 1'b0;
        clr_d = '0;
        if (op_valid) begin
            case (op)
                OP_LOAD_CNT: begin
                    vsr_d[CNT_LSB +: FLD_W] = cnt_val;
                    cc_d = cnt_cc;
                end
                OP_LOAD_IDX: begin
                    vsr_d[IDX_LSB +: FLD_W] = idx_val;
                    cc_d = idx_cc;
                end
                OP_SET_MODE: vsr_d[MODE_BIT] = operand[0];
                OP_CLEAR: begin
                    vsr_d[IDX_LSB +: FLD_W]   = '0;
                    vsr_d[INUSE_LSB +: PAIRS] = vsr_q[INUSE_LSB +: PAIRS] & ~operand[PAIRS-1:0];
                    clr_d = operand[PAIRS-1:0];
                end
                OP_RESTORE: begin
                    if (rst_ok) begin
                        vsr_d = rst_word;
                        clr_d = rst_clr;
                    end else begin
                        err_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and pulse registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsr_q  <= '0;
            cc_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            clr_q  <= '0;
        end else begin
            vsr_q  <= vsr_d;
            cc_q   <= cc_d;
            done_q <= op_valid;
            err_q  <= err_d;
            clr_q  <= clr_d;
        end
    end

    assign vsr      = vsr_q;
    assign cc       = cc_q;
    assign done     = done_q;
    assign spec_err = err_q;
    assign pair_clr = clr_q;

    // R2: the stored count never exceeds the section size
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vsr[CNT_LSB +: FLD_W] <= SECT_F);

    // R3: the stored index never exceeds the section size
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsr[IDX_LSB +: FLD_W] <= SECT_F);

    // R6: reserved bits can never be loaded
    p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsr[RSV_W-1:0] == '0);

    // R6: a rejected restore leaves the word as it was
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> (vsr == $past(vsr) && pair_clr == '0));

    // R5: a strobed pair is never left marked in use
    p_clr_inuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_clr != '0) |-> ((vsr[INUSE_LSB +: PAIRS] & pair_clr) == '0));

    // R10: every accepted operation completes one cycle later
    p_done_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    // R11: an idle cycle keeps the word and code
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(vsr) && $stable(cc) && !done && !spec_err && pair_clr == '0));
endmodule

// File: tb/test_vsr_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks for reset, idle cycles and a reset during activity.
module test_vsr_ctrl;
    localparam int SECT = 16;
    localparam int NVEC = 22;

    typedef struct packed {
        logic [2:0]  op;
        logic        prob;
        logic [63:0] opnd;
        logic [63:0] e_vsr;
        logic [1:0]  e_cc;
        logic        e_err;
        logic [7:0]  e_clr;
    } vec_t;

    // Each row: op, problem state, operand, expected word, code, error, clears
    localparam vec_t TBL [NVEC] = '{
        '{3'd1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'd0, 1'b0, 8'h00}, // R2 zero
        '{3'd1, 1'b0, 64'h0000_0000_FFFF_FFFB, 64'h0000_0000_0000_0000, 2'd1, 1'b0, 8'h00}, // R2 negative
        '{3'd1, 1'b0, 64'h0000_0000_0000_0011, 64'h0000_0010_0000_0000, 2'd2, 1'b0, 8'h00}, // R2 above
        '{3'd1, 1'b0, 64'h0000_0000_0000_0010, 64'h0000_0010_0000_0000, 2'd3, 1'b0, 8'h00}, // R2 at limit
        '{3'd1, 1'b0, 64'h0000_0000_0000_0009, 64'h0000_0009_0000_0000, 2'd3, 1'b0, 8'h00}, // R2 inside
        '{3'd2, 1'b0, 64'h0000_0000_0000_0004, 64'h0000_0009_0004_0000, 2'd2, 1'b0, 8'h00}, // R3 below count
        '{3'd2, 1'b0, 64'h0000_0000_0000_0009, 64'h0000_0009_0009_0000, 2'd3, 1'b0, 8'h00}, // R3 at count
        '{3'd2, 1'b0, 64'h0000_0000_0000_0028, 64'h0000_0009_0010_0000, 2'd3, 1'b0, 8'h00}, // R3 clamp high
        '{3'd2, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0009_0000_0000, 2'd1, 1'b0, 8'h00}, // R3 negative
        '{3'd2, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0009_0000_0000, 2'd0, 1'b0, 8'h00}, // R3 zero
        '{3'd3, 1'b0, 64'h0000_0000_0000_0003, 64'h0000_0009_0000_8000, 2'd0, 1'b0, 8'h00}, // R4 set
        '{3'd3, 1'b0, 64'h0000_0000_0000_0002, 64'h0000_0009_0000_0000, 2'd0, 1'b0, 8'h00}, // R4 clear
        '{3'd5, 1'b0, 64'hF0A5_0005_0003_8000, 64'hF0A5_0005_0003_8000, 2'd0, 1'b0, 8'h00}, // R7
        '{3'd5, 1'b0, 64'h0F00_0001_0001_0001, 64'hF0A5_0005_0003_8000, 2'd0, 1'b1, 8'h00}, // R6 reserved
        '{3'd5, 1'b0, 64'h0F00_0011_0000_0000, 64'hF0A5_0005_0003_8000, 2'd0, 1'b1, 8'h00}, // R6 count
        '{3'd5, 1'b0, 64'h0F00_0001_0010_0000, 64'hF0A5_0005_0003_8000, 2'd0, 1'b1, 8'h00}, // R6 index
        '{3'd5, 1'b1, 64'h3C00_0010_000F_0000, 64'h3C3C_0010_000F_0000, 2'd0, 1'b0, 8'hC0}, // R8 R9 edges
        '{3'd4, 1'b0, 64'h0000_0000_0000_0014, 64'h283C_0010_0000_0000, 2'd0, 1'b0, 8'h14}, // R5
        '{3'd2, 1'b0, 64'h0000_0000_0000_0014, 64'h283C_0010_0010_0000, 2'd3, 1'b0, 8'h00}, // R3 full count
        '{3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h283C_0010_0010_0000, 2'd3, 1'b0, 8'h00}, // R10 unused code
        '{3'd5, 1'b1, 64'h8155_0002_0001_0000, 64'h8181_0002_0001_0000, 2'd3, 1'b0, 8'h28}, // R8 R9
        '{3'd1, 1'b0, 64'h0000_0000_0000_0000, 64'h8181_0000_0001_0000, 2'd0, 1'b0, 8'h00}  // R2 cc back to 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [63:0] operand = '0;
    logic        prob_state = 1'b0;
    logic [63:0] vsr;
    logic [1:0]  cc;
    logic        done;
    logic        spec_err;
    logic [7:0]  pair_clr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vsr_ctrl #(.SECT_SIZE(SECT)) i_vsr_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .prob_state(prob_state), .vsr(vsr), .cc(cc),
        .done(done), .spec_err(spec_err), .pair_clr(pair_clr)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one operation on a falling edge; results are read one cycle later
    task automatic run_op(input logic [2:0] o, input logic [63:0] d, input logic p);
        @(negedge clk);
        op_valid = 1'b1; op_code = o; operand = d; prob_state = p;
        @(negedge clk);
        op_valid = 1'b0; op_code = '0; operand = '0; prob_state = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 vsr", vsr, 64'h0);
        check("R1 cc", {62'h0, cc}, 64'h0);
        check("R1 pulses", {54'h0, done, spec_err, pair_clr}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_op(TBL[i].op, TBL[i].opnd, TBL[i].prob);
            check($sformatf("R2-R9 row %0d vsr", i), vsr, TBL[i].e_vsr);
            check($sformatf("R2 R3 row %0d cc", i), {62'h0, cc}, {62'h0, TBL[i].e_cc});
            check($sformatf("R6 row %0d spec_err", i), {63'h0, spec_err}, {63'h0, TBL[i].e_err});
            check($sformatf("R5 R9 row %0d pair_clr", i), {56'h0, pair_clr}, {56'h0, TBL[i].e_clr});
            check($sformatf("R10 row %0d done", i), {63'h0, done}, 64'h1);
        end

        // R11: idle cycles keep everything and produce no pulses
        @(negedge clk);
        check("R11 idle vsr", vsr, 64'h8181_0000_0001_0000);
        check("R11 idle cc", {62'h0, cc}, 64'h0);
        check("R11 idle pulses", {54'h0, done, spec_err, pair_clr}, 64'h0);

        // R10: code 0 pulses done and changes nothing
        run_op(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check("R10 nop done", {63'h0, done}, 64'h1);
        check("R10 nop vsr", vsr, 64'h8181_0000_0001_0000);

        // R5: clear all pairs while nothing outside the mask moves
        run_op(3'd4, 64'h0000_0000_0000_00FF, 1'b0);
        check("R5 all vsr", vsr, 64'h0081_0000_0000_0000);
        check("R5 all pair_clr", {56'h0, pair_clr}, 64'hFF);

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b1; op_code = 3'd1; operand = 64'h5;
        @(negedge clk);
        op_valid = 1'b0; op_code = '0; operand = '0;
        check("R1 mid vsr", vsr, 64'h0);
        check("R1 mid done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end
endmodule